// File: doc/BRIEF.md
# Safety status and access error monitor

This block gathers hardware safety events and illegal software accesses for a random number generator and turns them into a small set of sticky status flags, a typed record of the last bad access, a combined safety-error flag and a maskable interrupt line. Hardware events are a clock-glitch pulse, a sequencer fault pulse, a redundant-register error pulse and a level that shows a software-injected fault is present. The block also watches the register bus strobes and address. It detects reads of the output data register that come at the wrong time, and writes to write-protected registers while protection is on.

Two status registers have their own clear-on-read behaviour. Reading the protection status register clears the four event flags. Reading the interrupt status register clears the combined safety-error flag. In both cases an event in the same cycle as the clearing read takes priority. Write-protected writes are blocked at the source: the block forwards a write strobe to the register file only when the write is allowed. The glitch detector and the protected registers themselves live outside this block.

Top module: `safety_status_monitor`

## Requirements
- R1: After a synchronous active-low reset, all status flags, `stat_inj`, `sece_flag` and `irq` are 0. `err_type` and `err_class` are also 0.
- R2: A read of the data register (address 0x50) while `gen_enable` is 0 sets `stat_sw` on the next cycle. It also records `err_type`=1 and `err_class`=2.
- R3: A read of the data register while `gen_enable` is 1 and `data_ready` is 0 sets `stat_sw` and records `err_type`=2 and `err_class`=1. A read with both inputs at 1 is not an error.
- R4: A write to an address in 0x04..0x0F while `wp_enable` is 1 keeps `wr_allow` at 0. It sets `stat_wpv` and records `err_type`=3 and `err_class`=3. Any other write gives `wr_allow`=1 in that same cycle.
- R5: An `evt_clk_glitch` pulse sets `stat_glitch`. An `evt_seq_fault` or `evt_redund_err` pulse sets `stat_seq`. Both flags show the event one cycle later and stay set.
- R6: A read of the protection status register (address 0xE8) clears `stat_glitch`, `stat_seq`, `stat_sw` and `stat_wpv` on the next cycle. This read leaves `sece_flag`, `err_type` and `err_class` unchanged.
- R7: An event that arrives in the same cycle as the read that would clear its flag wins, and the flag stays 1.
- R8: `sece_flag` is set one cycle after any event that sets one of the four flags. It is also set in every cycle after one in which `evt_fault_injected` is 1. `stat_inj` follows `evt_fault_injected` with one cycle of delay.
- R9: A read of the interrupt status register (address 0x1C) clears `sece_flag` on the next cycle, unless a setting event or an injected fault is present in that same cycle.
- R10: `irq` is 1 exactly when `sece_flag` is 1 and `sece_mask` is 1.
- R11: `err_type` and `err_class` hold the most recent error until a newer one arrives. A protected write takes priority over a bad read, and a read while disabled takes priority over a read without data ready.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| evt_clk_glitch | input | 1 | Clock-glitch event pulse |
| evt_seq_fault | input | 1 | Sequencer abnormal-state pulse |
| evt_redund_err | input | 1 | Redundant-register majority or parity error pulse |
| evt_fault_injected | input | 1 | Level: a software-injected fault is present |
| gen_enable | input | 1 | Generator enabled |
| data_ready | input | 1 | Output data valid flag |
| wp_enable | input | 1 | Write protection enabled |
| sece_mask | input | 1 | Interrupt mask for the safety-error flag |
| bus_rd | input | 1 | Register read strobe |
| bus_wr | input | 1 | Register write strobe |
| bus_addr | input | ADDR_W | Register address |
| wr_allow | output | 1 | Write strobe forwarded to the register file |
| stat_glitch | output | 1 | Sticky clock-glitch flag |
| stat_seq | output | 1 | Sticky sequencer/redundancy error flag |
| stat_sw | output | 1 | Sticky software-access error flag |
| stat_wpv | output | 1 | Sticky write-protection violation flag |
| stat_inj | output | 1 | Injected-fault indication, registered |
| err_type | output | 2 | Last error type code |
| err_class | output | 2 | Criticality class of the last error |
| sece_flag | output | 1 | Combined safety-error flag |
| irq | output | 1 | Masked interrupt line |

## Verification
A flag can be set and cleared in the same cycle in two ways. A glitch, sequencer or access error can arrive together with a protection-status read, and an event or an injected fault can arrive together with an interrupt-status read. The bench drives each of these collisions on purpose and then repeats them many times in a random phase that mixes pulses with reads of both status addresses. The cycle reference model applies the rule that the event wins to every flag, and every output is compared against it on every clock. So an inverted priority shows up as a flag that is 0 where the model expects 1.

// File: rtl/ssm_pkg.sv
// Package: shared codes for the safety status monitor.
// Assumes a two-bit error type and a two-bit criticality class.
package ssm_pkg;

    typedef enum logic [1:0] {
        ERR_NONE     = 2'd0,
        ERR_RD_OFF   = 2'd1,
        ERR_RD_EMPTY = 2'd2,
        ERR_WR_PROT  = 2'd3
    } err_type_e;

    localparam int FLAG_GLITCH = 0;
    localparam int FLAG_SEQ    = 1;
    localparam int FLAG_SW     = 2;
    localparam int FLAG_WPV    = 3;
    localparam int NFLAG       = 4;

    // Map an error type to its criticality class
    function automatic logic [1:0] class_of(err_type_e t);
        case (t)
            ERR_RD_EMPTY: return 2'd1;
            ERR_RD_OFF:   return 2'd2;
            ERR_WR_PROT:  return 2'd3;
            default:      return 2'd0;
        endcase
    endfunction

endpackage

// File: rtl/ssm_access_decode.sv
// Module: classifies one bus access as legal, a bad data read or a
// blocked protected write. Purely combinational.
// Assumes at most one access per cycle; if read and write coincide,
// the protected-write code is chosen.
module ssm_access_decode
    import ssm_pkg::*;
#(
    parameter int unsigned           ADDR_W  = 8,
    parameter logic [ADDR_W-1:0]     A_ODATA = 8'h50,
    parameter logic [ADDR_W-1:0]     PROT_LO = 8'h04,
    parameter logic [ADDR_W-1:0]     PROT_HI = 8'h0F
) (
    input  logic              bus_rd,
    input  logic              bus_wr,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic              gen_enable,
    input  logic              data_ready,
    input  logic              wp_enable,
    output logic              sw_err,
    output logic              wpv_err,
    output logic              err_valid,
    output err_type_e         err_code,
    output logic              wr_allow
);

    logic in_prot;
    logic od_rd;
    logic rd_off;
    logic rd_empty;

    // Address window and access classification
    always_comb begin
        in_prot  = (bus_addr >= PROT_LO) && (bus_addr <= PROT_HI);
        od_rd    = bus_rd && (bus_addr == A_ODATA);
        rd_off   = od_rd && !gen_enable;
        rd_empty = od_rd && gen_enable && !data_ready;
        wpv_err  = bus_wr && wp_enable && in_prot;
        sw_err   = rd_off || rd_empty;
        wr_allow = bus_wr && !wpv_err;
    end

    // Priority encode the error type of this cycle
    always_comb begin
        err_valid = wpv_err || sw_err;
        if (wpv_err)
            err_code = ERR_WR_PROT;
        else if (rd_off)
            err_code = ERR_RD_OFF;
        else if (rd_empty)
            err_code = ERR_RD_EMPTY;
        else
            err_code = ERR_NONE;
    end

endmodule

// File: rtl/ssm_sticky_flag.sv
// Module: one sticky status bit with set-over-clear priority.
// Assumes synchronous active-low reset.
module ssm_sticky_flag (
    input  logic clk,
    input  logic rst_n,
    input  logic set_i,
    input  logic clr_i,
    output logic flag_o
);

    // Hold, set or clear the flag; set wins over clear
    always_ff @(posedge clk) begin
        if (!rst_n)
            flag_o <= 1'b0;
        else if (set_i)
            flag_o <= 1'b1;
        else if (clr_i)
            flag_o <= 1'b0;
    end

endmodule

// File: rtl/ssm_err_record.sv
// Module: remembers the type and class of the most recent access error.
// Assumes err_code is valid whenever err_valid is high.
module ssm_err_record
    import ssm_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       err_valid,
    input  err_type_e  err_code,
    output logic [1:0] err_type,
    output logic [1:0] err_class
);

    // Capture the newest error; otherwise hold
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            err_type  <= 2'd0;
            err_class <= 2'd0;
        end else if (err_valid) begin
            err_type  <= err_code;
            err_class <= class_of(err_code);
        end
    end

endmodule

// File: rtl/safety_status_monitor.sv
// Module: top of the safety status monitor. Collects hardware safety
// events and illegal accesses into sticky flags, keeps the last error
// record, and forms the combined safety-error flag and interrupt.
// Assumes event inputs are synchronous single-cycle pulses, except
// evt_fault_injected, which is a level.
module safety_status_monitor
    import ssm_pkg::*;
#(
    parameter int unsigned           ADDR_W  = 8,
    parameter logic [ADDR_W-1:0]     A_ODATA = 8'h50,
    parameter logic [ADDR_W-1:0]     A_ISR   = 8'h1C,
    parameter logic [ADDR_W-1:0]     A_WPSR  = 8'hE8,
    parameter logic [ADDR_W-1:0]     PROT_LO = 8'h04,
    parameter logic [ADDR_W-1:0]     PROT_HI = 8'h0F
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              evt_clk_glitch,
    input  logic              evt_seq_fault,
    input  logic              evt_redund_err,
    input  logic              evt_fault_injected,
    input  logic              gen_enable,
    input  logic              data_ready,
    input  logic              wp_enable,
    input  logic              sece_mask,
    input  logic              bus_rd,
    input  logic              bus_wr,
    input  logic [ADDR_W-1:0] bus_addr,
    output logic              wr_allow,
    output logic              stat_glitch,
    output logic              stat_seq,
    output logic              stat_sw,
    output logic              stat_wpv,
    output logic              stat_inj,
    output logic [1:0]        err_type,
    output logic [1:0]        err_class,
    output logic              sece_flag,
    output logic              irq
);

    logic             sw_err;
    logic             wpv_err;
    logic             err_valid;
    err_type_e        err_code;
    logic             wpsr_rd;
    logic             isr_rd;
    logic [NFLAG-1:0] flag_set;
    logic [NFLAG-1:0] flag_q;
    logic             sece_set;

    ssm_access_decode #(
        .ADDR_W  (ADDR_W),
        .A_ODATA (A_ODATA),
        .PROT_LO (PROT_LO),
        .PROT_HI (PROT_HI)
    ) u_dec (
        .bus_rd     (bus_rd),
        .bus_wr     (bus_wr),
        .bus_addr   (bus_addr),
        .gen_enable (gen_enable),
        .data_ready (data_ready),
        .wp_enable  (wp_enable),
        .sw_err     (sw_err),
        .wpv_err    (wpv_err),
        .err_valid  (err_valid),
        .err_code   (err_code),
        .wr_allow   (wr_allow)
    );

    // Status-register read strobes and per-flag set sources
    always_comb begin
        wpsr_rd               = bus_rd && (bus_addr == A_WPSR);
        isr_rd                = bus_rd && (bus_addr == A_ISR);
        flag_set[FLAG_GLITCH] = evt_clk_glitch;
        flag_set[FLAG_SEQ]    = evt_seq_fault || evt_redund_err;
        flag_set[FLAG_SW]     = sw_err;
        flag_set[FLAG_WPV]    = wpv_err;
        sece_set              = (|flag_set) || evt_fault_injected;
    end

    genvar gi;
    generate
        for (gi = 0; gi < NFLAG; gi++) begin : g_flag
            ssm_sticky_flag u_flag (
                .clk    (clk),
                .rst_n  (rst_n),
                .set_i  (flag_set[gi]),
                .clr_i  (wpsr_rd),
                .flag_o (flag_q[gi])
            );
        end
    endgenerate

    ssm_sticky_flag u_sece (
        .clk    (clk),
        .rst_n  (rst_n),
        .set_i  (sece_set),
        .clr_i  (isr_rd),
        .flag_o (sece_flag)
    );

    ssm_err_record u_rec (
        .clk       (clk),
        .rst_n     (rst_n),
        .err_valid (err_valid),
        .err_code  (err_code),
        .err_type  (err_type),
        .err_class (err_class)
    );

    // Register the injected-fault level for the status view
    always_ff @(posedge clk) begin
        if (!rst_n)
            stat_inj <= 1'b0;
        else
            stat_inj <= evt_fault_injected;
    end

    // Drive the status outputs and the masked interrupt
    always_comb begin
        stat_glitch = flag_q[FLAG_GLITCH];
        stat_seq    = flag_q[FLAG_SEQ];
        stat_sw     = flag_q[FLAG_SW];
        stat_wpv    = flag_q[FLAG_WPV];
        irq         = sece_flag && sece_mask;
    end

endmodule

// File: rtl/ssm_checker.sv
// Module: property checker for the safety status monitor, attached by bind.
// Assumes the same parameter values as the module it observes.
module ssm_checker #(
    parameter int unsigned           ADDR_W  = 8,
    parameter logic [ADDR_W-1:0]     A_ODATA = 8'h50,
    parameter logic [ADDR_W-1:0]     A_ISR   = 8'h1C,
    parameter logic [ADDR_W-1:0]     A_WPSR  = 8'hE8,
    parameter logic [ADDR_W-1:0]     PROT_LO = 8'h04,
    parameter logic [ADDR_W-1:0]     PROT_HI = 8'h0F
) (
    input logic              clk,
    input logic              rst_n,
    input logic              evt_clk_glitch,
    input logic              evt_seq_fault,
    input logic              evt_redund_err,
    input logic              evt_fault_injected,
    input logic              gen_enable,
    input logic              data_ready,
    input logic              wp_enable,
    input logic              sece_mask,
    input logic              bus_rd,
    input logic              bus_wr,
    input logic [ADDR_W-1:0] bus_addr,
    input logic              wr_allow,
    input logic              stat_glitch,
    input logic              stat_seq,
    input logic              stat_sw,
    input logic              stat_wpv,
    input logic              stat_inj,
    input logic [1:0]        err_type,
    input logic [1:0]        err_class,
    input logic              sece_flag,
    input logic              irq
);

    logic prot_wr;
    logic od_rd;
    logic any_ev;
    logic wpsr_rd;
    logic isr_rd;

    // Observation terms built from the ports
    always_comb begin
        prot_wr = bus_wr && wp_enable && (bus_addr >= PROT_LO) && (bus_addr <= PROT_HI);
        od_rd   = bus_rd && (bus_addr == A_ODATA);
        wpsr_rd = bus_rd && (bus_addr == A_WPSR);
        isr_rd  = bus_rd && (bus_addr == A_ISR);
        any_ev  = evt_clk_glitch || evt_seq_fault || evt_redund_err || prot_wr ||
                  (od_rd && !(gen_enable && data_ready));
    end

    assert_rd_off_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (od_rd && !gen_enable && !prot_wr) |=> (stat_sw && err_type == 2'd1 && err_class == 2'd2));

    assert_rd_empty_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (od_rd && gen_enable && !data_ready && !prot_wr) |=> (stat_sw && err_type == 2'd2 && err_class == 2'd1));

    assert_prot_block_R4: assert property (@(posedge clk) disable iff (!rst_n)
        prot_wr |-> !wr_allow);

    assert_prot_flag_R4: assert property (@(posedge clk) disable iff (!rst_n)
        prot_wr |=> (stat_wpv && err_type == 2'd3 && err_class == 2'd3));

    assert_glitch_set_R5: assert property (@(posedge clk) disable iff (!rst_n)
        evt_clk_glitch |=> stat_glitch);

    assert_wpsr_clear_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (wpsr_rd && !any_ev) |=> (!stat_glitch && !stat_seq && !stat_sw && !stat_wpv));

    assert_event_wins_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (wpsr_rd && (evt_seq_fault || evt_redund_err)) |=> stat_seq);

    assert_sece_set_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (any_ev || evt_fault_injected) |=> sece_flag);

    assert_inj_follow_R8: assert property (@(posedge clk) disable iff (!rst_n)
        evt_fault_injected |=> stat_inj);

    assert_isr_clear_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (isr_rd && !any_ev && !evt_fault_injected) |=> !sece_flag);

    assert_irq_mask_R10: assert property (@(posedge clk) disable iff (!rst_n)
        irq |-> (sece_flag && sece_mask));

    assert_irq_raise_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (sece_flag && sece_mask) |-> irq);

endmodule

bind safety_status_monitor ssm_checker #(
    .ADDR_W  (ADDR_W),
    .A_ODATA (A_ODATA),
    .A_ISR   (A_ISR),
    .A_WPSR  (A_WPSR),
    .PROT_LO (PROT_LO),
    .PROT_HI (PROT_HI)
) u_chk (.*);

// File: tb/sim_safety_status_monitor.sv
// Bench: behavioural reference model compared with the design every clock,
// plus directed checks on the cases the requirements name.
module sim_safety_status_monitor;

    localparam logic [7:0] OD   = 8'h50;
    localparam logic [7:0] ISR  = 8'h1C;
    localparam logic [7:0] WPSR = 8'hE8;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       evt_clk_glitch = 0, evt_seq_fault = 0, evt_redund_err = 0, evt_fault_injected = 0;
    logic       gen_enable = 0, data_ready = 0, wp_enable = 0, sece_mask = 0;
    logic       bus_rd = 0, bus_wr = 0;
    logic [7:0] bus_addr = 8'h00;
    logic       wr_allow, stat_glitch, stat_seq, stat_sw, stat_wpv, stat_inj, sece_flag, irq;
    logic [1:0] err_type, err_class;

    integer n_tests = 0;
    integer n_fail  = 0;
    bit     done    = 0;

    // Reference state
    bit       m_gl, m_sq, m_sw, m_wp, m_inj, m_sece;
    bit [1:0] m_type, m_class;

    always #10 clk = ~clk;

    safety_status_monitor u0 (
        .clk(clk), .rst_n(rst_n),
        .evt_clk_glitch(evt_clk_glitch), .evt_seq_fault(evt_seq_fault),
        .evt_redund_err(evt_redund_err), .evt_fault_injected(evt_fault_injected),
        .gen_enable(gen_enable), .data_ready(data_ready), .wp_enable(wp_enable),
        .sece_mask(sece_mask), .bus_rd(bus_rd), .bus_wr(bus_wr), .bus_addr(bus_addr),
        .wr_allow(wr_allow), .stat_glitch(stat_glitch), .stat_seq(stat_seq),
        .stat_sw(stat_sw), .stat_wpv(stat_wpv), .stat_inj(stat_inj),
        .err_type(err_type), .err_class(err_class), .sece_flag(sece_flag), .irq(irq)
    );

    task automatic chk(input string req, input string what, input integer act, input integer exp);
        n_tests++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    // Reference model: next state from the requirements
    always @(posedge clk) begin
        bit prot, odr, wv, roff, remp, any, wrd, ird;
        if (!rst_n) begin
            m_gl <= 0; m_sq <= 0; m_sw <= 0; m_wp <= 0; m_inj <= 0; m_sece <= 0;
            m_type <= 0; m_class <= 0;
        end else begin
            prot = (bus_addr >= 8'h04) && (bus_addr <= 8'h0F);
            odr  = bus_rd && bus_addr == OD;
            wv   = bus_wr && wp_enable && prot;
            roff = odr && !gen_enable;
            remp = odr && gen_enable && !data_ready;
            wrd  = bus_rd && bus_addr == WPSR;
            ird  = bus_rd && bus_addr == ISR;
            any  = evt_clk_glitch || evt_seq_fault || evt_redund_err || wv || roff || remp;
            m_gl <= evt_clk_glitch ? 1'b1 : (wrd ? 1'b0 : m_gl);
            m_sq <= (evt_seq_fault || evt_redund_err) ? 1'b1 : (wrd ? 1'b0 : m_sq);
            m_sw <= (roff || remp) ? 1'b1 : (wrd ? 1'b0 : m_sw);
            m_wp <= wv ? 1'b1 : (wrd ? 1'b0 : m_wp);
            m_sece <= (any || evt_fault_injected) ? 1'b1 : (ird ? 1'b0 : m_sece);
            m_inj <= evt_fault_injected;
            if (wv) begin m_type <= 3; m_class <= 3; end
            else if (roff) begin m_type <= 1; m_class <= 2; end
            else if (remp) begin m_type <= 2; m_class <= 1; end
        end
    end

    // Compare every output on every clock, away from the edge
    always @(negedge clk) begin
        if (rst_n && !done) begin
            chk("R5", "stat_glitch", stat_glitch, m_gl);
            chk("R5", "stat_seq", stat_seq, m_sq);
            chk("R2", "stat_sw", stat_sw, m_sw);
            chk("R4", "stat_wpv", stat_wpv, m_wp);
            chk("R8", "stat_inj", stat_inj, m_inj);
            chk("R11", "err_type", err_type, m_type);
            chk("R11", "err_class", err_class, m_class);
            chk("R8", "sece_flag", sece_flag, m_sece);
            chk("R10", "irq", irq, m_sece && sece_mask);
            chk("R4", "wr_allow", wr_allow,
                bus_wr && !(wp_enable && bus_addr >= 8'h04 && bus_addr <= 8'h0F));
        end
    end

    task automatic idle();
        evt_clk_glitch = 0; evt_seq_fault = 0; evt_redund_err = 0;
        bus_rd = 0; bus_wr = 0; bus_addr = 8'h00;
    endtask

    // Advance so the inputs just applied have been captured
    task automatic cyc();
        @(posedge clk);
        #2;
    endtask

    task automatic rd(input logic [7:0] a);
        bus_rd = 1; bus_addr = a;
    endtask

    initial begin
        #(20 * 200000);
        if (!done) begin
            done = 1;
            n_tests++; n_fail++;
            $display("FAIL watchdog: actual hung expected finished");
            $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end

    initial begin
        #2;
        cyc(); cyc();
        // R1: reset state
        chk("R1", "stat_glitch", stat_glitch, 0);
        chk("R1", "stat_sw", stat_sw, 0);
        chk("R1", "err_type", err_type, 0);
        chk("R1", "sece_flag", sece_flag, 0);
        chk("R1", "irq", irq, 0);
        rst_n = 1; sece_mask = 1;
        cyc();

        // R2: read while disabled
        rd(OD); cyc(); idle();
        chk("R2", "stat_sw", stat_sw, 1);
        chk("R2", "err_type", err_type, 1);
        chk("R2", "err_class", err_class, 2);
        chk("R10", "irq", irq, 1);

        // R9: interrupt-status read clears sece, not the flags
        rd(ISR); cyc(); idle();
        chk("R9", "sece_flag", sece_flag, 0);
        chk("R9", "stat_sw", stat_sw, 1);

        // R3: enabled but no data ready, then a legal read
        gen_enable = 1; rd(OD); cyc(); idle();
        chk("R3", "err_type", err_type, 2);
        chk("R3", "err_class", err_class, 1);
        rd(ISR); cyc(); idle();
        data_ready = 1; rd(OD); cyc(); idle();
        chk("R3", "sece_flag legal read", sece_flag, 0);
        chk("R3", "err_type held", err_type, 2);

        // R11: read while disabled wins over not ready
        gen_enable = 0; data_ready = 0; rd(OD); cyc(); idle();
        chk("R11", "err_type", err_type, 1);

        // R6: protection-status read clears four flags only
        rd(WPSR); cyc(); idle();
        chk("R6", "stat_sw", stat_sw, 0);
        chk("R6", "sece_flag", sece_flag, 1);
        chk("R6", "err_type", err_type, 1);

        // R4: protected write blocked, outside write passes
        wp_enable = 1; bus_wr = 1; bus_addr = 8'h08; #1;
        chk("R4", "wr_allow blocked", wr_allow, 0);
        cyc(); idle();
        chk("R4", "stat_wpv", stat_wpv, 1);
        chk("R4", "err_type", err_type, 3);
        chk("R4", "err_class", err_class, 3);
        bus_wr = 1; bus_addr = 8'h10; #1;
        chk("R4", "wr_allow outside", wr_allow, 1);
        cyc(); idle();

        // R5 and R7: events in the same cycle as a clearing read
        evt_clk_glitch = 1; evt_redund_err = 1; rd(WPSR); cyc(); idle();
        chk("R7", "stat_glitch", stat_glitch, 1);
        chk("R7", "stat_seq", stat_seq, 1);
        chk("R7", "stat_wpv cleared", stat_wpv, 0);
        evt_seq_fault = 1; rd(ISR); cyc(); idle();
        chk("R7", "sece_flag", sece_flag, 1);

        // R8: injected fault keeps sece set across an ISR read
        evt_fault_injected = 1; rd(ISR); cyc(); idle();
        chk("R8", "sece_flag", sece_flag, 1);
        chk("R8", "stat_inj", stat_inj, 1);
        evt_fault_injected = 0; rd(ISR); cyc(); idle();
        chk("R8", "stat_inj", stat_inj, 0);
        chk("R9", "sece_flag", sece_flag, 0);

        // R10: masked
        evt_clk_glitch = 1; sece_mask = 0; cyc(); idle();
        chk("R10", "irq masked", irq, 0);

        // Random mix of events and reads
        for (int i = 0; i < 4000; i++) begin
            int r;
            idle();
            r = $urandom_range(0, 15);
            evt_clk_glitch     = ($urandom_range(0, 9) == 0);
            evt_seq_fault      = ($urandom_range(0, 11) == 0);
            evt_redund_err     = ($urandom_range(0, 13) == 0);
            evt_fault_injected = ($urandom_range(0, 19) == 0);
            gen_enable = $urandom_range(0, 1);
            data_ready = $urandom_range(0, 1);
            wp_enable  = $urandom_range(0, 1);
            sece_mask  = $urandom_range(0, 1);
            case (r)
                0, 1, 2: rd(WPSR);
                3, 4:    rd(ISR);
                5, 6:    rd(OD);
                7, 8:    begin bus_wr = 1; bus_addr = 8'($urandom_range(0, 31)); end
                9:       rd(8'h20);
                default: ;
            endcase
            cyc();
        end
        idle(); evt_fault_injected = 0;
        cyc(); cyc();
        done = 1;
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

endmodule